// File: doc/BRIEF.md
# Processor Power-Up Reset Sequencer

This block is a synchronous controller that orders the reset sequence between the board's power rails, a processor and the processor's companion bridge chip. It watches three asynchronous inputs: a supply-good level, a power-good level and a connect indication from the bridge. It drives two active-low reset outputs, one for the bridge and one for the processor. It also produces a one-cycle strobe that captures the processor's 4-bit frequency-ID code once that code has settled.

Every interval is a parameter counted in reference-clock cycles. The defaults assume a 100 MHz reference clock:

- 3 ms of clock settling after supply-good.
- 1 ms minimum PLL lock time.
- 1.75 ms from power-good to the release of processor reset.
- 100 ns of frequency-ID settling.

The sequence follows these rules:

- The processor leaves reset once per cold boot.
- The bridge reset must already be asserted, and a connect indication must have been seen, before the processor is released.
- A power-good that drops after it has been accepted is a fault. The fault forces both resets back on and latches until the controller itself is reset.

The parameters must satisfy `RELEASE_CYC >= PLL_MIN_CYC` and `RELEASE_CYC > FID_SETTLE_CYC`.

Top module: `pwr_seq`

## Requirements
- R1: While and after the synchronous active-low controller reset `rst_n` is applied, both reset outputs are low, and the strobe, the fault flag and the captured code are all zero.
- R2: Every asynchronous input passes through two flops. A change driven just before clock edge 1 reaches the state machine's decision at edge 3.
- R3: Power-good is not acted on until supply-good has been high for CLK_SETTLE_CYC cycles. With power-good already high when supply-good rises, processor reset releases at edge CLK_SETTLE_CYC+RELEASE_CYC+4, counting from the edge on which supply-good is first sampled. Without supply-good, nothing advances.
- R4: With connect already seen, processor reset releases at edge RELEASE_CYC+3, counting from the edge on which power-good is first sampled. This is never sooner than PLL_MIN_CYC cycles of synchronized power-good.
- R5: Processor reset stays asserted until connect has been seen while bridge reset is asserted. If connect arrives late, the release happens at edge 4 after connect is first sampled.
- R6: Exactly one one-cycle strobe is issued, at edge FID_SETTLE_CYC+3 after power-good is first sampled. The synchronized 4-bit code is latched into `fid_o` on that edge, and later input changes do not alter it.
- R7: If power-good falls after it has been accepted, the block enters a fault state within three edges. In that state `fault_o` is 1 and both reset outputs are 0. The fault holds even if power-good returns, and only `rst_n` clears it.
- R8: Processor reset is released only once per cold boot. After the release, changes on connect, supply-good and the frequency-ID inputs have no effect. Only a power-good drop can reassert processor reset.
- R9: Bridge reset is released on the same edge as processor reset, so it was asserted on the cycle before the processor release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| supply_ok_i | input | 1 | Asynchronous supply-good level |
| pwr_ok_i | input | 1 | Asynchronous power-good level, expected monotonic |
| connect_i | input | 1 | Asynchronous connect indication from the bridge |
| fid_i | input | FID_W | Asynchronous frequency-ID code from the processor |
| bridge_rst_n_o | output | 1 | Active-low bridge reset |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| fid_stb_o | output | 1 | One-cycle capture strobe |
| fid_o | output | FID_W | Latched frequency-ID code |
| fault_o | output | 1 | Sticky power-good monotonicity fault |

## Verification
The bench measures exact edge counts for the processor release, the strobe and the fault entry. A design that miscounts a synchronizer stage or loads a timer one short would be off by a cycle and is caught. Power-good is raised during clock settling, to catch a design that skips the settle wait, and connect is withheld past the release time, to catch a design that releases the processor without the handshake evidence. Power-good is dropped both in the hold window and after release, then restored, to catch a fault that is not sticky or a sequence that restarts a second time. The frequency-ID inputs and connect are changed after capture and release, to catch a latch that follows its input or a release that reacts to late traffic.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power-up reset sequencer.
package pwr_seq_pkg;

    // Sequencer states in boot order, then the terminal fault state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CLK,
        ST_WAIT_PWR,
        ST_FID_SETTLE,
        ST_HOLD_RESET,
        ST_RELEASE,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/pwr_seq_sync.sv
// Two-flop synchronizer for a bundle of asynchronous levels.
// Assumes each bit is a slowly changing level; bits are not kept coherent
// with each other, which is acceptable because every bit is used alone.
module pwr_seq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two stages per bit; synchronous reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/pwr_seq_timer.sv
// Loadable down-counter. A load of N makes done_o rise N-1 cycles later,
// so a state that loads on entry and leaves on done lasts exactly N cycles.
// Assumes load values are at least 1. Holds at zero once expired.
module pwr_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load N-1, then count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done_o = (cnt_q == '0);

    // R4: an expired timer stays expired until it is reloaded.
    a_r4_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> done_o);

endmodule

// File: rtl/pwr_seq_fsm.sv
// Boot-order state machine. It consumes synchronized levels, runs the
// settle, strobe and hold intervals on one shared timer, and registers every
// output from the next state, so outputs change only on state transitions.
// Assumes RELEASE_CYC >= PLL_MIN_CYC and RELEASE_CYC > FID_SETTLE_CYC.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int CLK_SETTLE_CYC = 300000,
    parameter int PLL_MIN_CYC    = 100000,
    parameter int RELEASE_CYC    = 175000,
    parameter int FID_SETTLE_CYC = 10,
    parameter int FID_W          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_s_i,
    input  logic             pg_s_i,
    input  logic             con_s_i,
    input  logic [FID_W-1:0] fid_s_i,
    output logic             bridge_rst_n_o,
    output logic             cpu_rst_n_o,
    output logic             fid_stb_o,
    output logic [FID_W-1:0] fid_o,
    output logic             fault_o
);

    localparam int MAX_CYC  = (CLK_SETTLE_CYC > RELEASE_CYC) ? CLK_SETTLE_CYC : RELEASE_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int HOLD_CYC = RELEASE_CYC - FID_SETTLE_CYC;
    localparam logic [CNT_W-1:0] K_CLK  = CNT_W'(CLK_SETTLE_CYC);
    localparam logic [CNT_W-1:0] K_PLL  = CNT_W'(PLL_MIN_CYC);
    localparam logic [CNT_W-1:0] K_REL  = CNT_W'(RELEASE_CYC);
    localparam logic [CNT_W-1:0] K_FID  = CNT_W'(FID_SETTLE_CYC);
    localparam logic [CNT_W-1:0] K_HOLD = CNT_W'(HOLD_CYC);

    seq_state_t       state_q, nxt;
    logic             t_load, t_done, seen_q;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] pg_cnt_q, sup_cnt_q;

    pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .done_o (t_done)
    );

    // Next-state and timer-load decode.
    always_comb begin
        nxt    = state_q;
        t_load = 1'b0;
        t_val  = '0;
        case (state_q)
            ST_IDLE: if (sup_s_i) begin
                nxt = ST_WAIT_CLK; t_load = 1'b1; t_val = K_CLK;
            end
            ST_WAIT_CLK: if (t_done) nxt = ST_WAIT_PWR;
            ST_WAIT_PWR: if (pg_s_i) begin
                nxt = ST_FID_SETTLE; t_load = 1'b1; t_val = K_FID;
            end
            ST_FID_SETTLE: begin
                if (!pg_s_i) nxt = ST_FAULT;
                else if (t_done) begin
                    nxt = ST_HOLD_RESET; t_load = 1'b1; t_val = K_HOLD;
                end
            end
            ST_HOLD_RESET: begin
                if (!pg_s_i) nxt = ST_FAULT;
                else if (t_done && seen_q) nxt = ST_RELEASE;
            end
            ST_RELEASE: if (!pg_s_i) nxt = ST_FAULT;
            default: nxt = ST_FAULT;
        endcase
    end

    // State and registered outputs, all derived from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            bridge_rst_n_o <= 1'b0;
            cpu_rst_n_o    <= 1'b0;
            fid_stb_o      <= 1'b0;
            fault_o        <= 1'b0;
        end else begin
            state_q        <= nxt;
            bridge_rst_n_o <= (nxt == ST_RELEASE);
            cpu_rst_n_o    <= (nxt == ST_RELEASE);
            fid_stb_o      <= (state_q == ST_FID_SETTLE) && (nxt == ST_HOLD_RESET);
            fault_o        <= (nxt == ST_FAULT);
        end
    end

    // Frequency-ID capture on the strobe-issuing transition only.
    always_ff @(posedge clk) begin
        if (!rst_n) fid_o <= '0;
        else if ((state_q == ST_FID_SETTLE) && (nxt == ST_HOLD_RESET)) fid_o <= fid_s_i;
    end

    // Sticky record that connect was seen while bridge reset was asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (con_s_i && !bridge_rst_n_o) seen_q <= 1'b1;
    end

    // Saturating counts of synchronized power-good and supply-good cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_cnt_q  <= '0;
            sup_cnt_q <= '0;
        end else begin
            if (pg_s_i && pg_cnt_q != K_REL) pg_cnt_q <= pg_cnt_q + CNT_W'(1);
            if (sup_s_i && sup_cnt_q != K_CLK) sup_cnt_q <= sup_cnt_q + CNT_W'(1);
        end
    end

    // R4: processor leaves reset only after the PLL lock minimum.
    a_r4_pll_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> (pg_cnt_q >= K_PLL));
    // R5: release requires connect seen; R9: bridge reset asserted just before.
    a_r5_connect_seen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> seen_q);
    a_r9_bridge_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> $past(!bridge_rst_n_o));
    // R6: the strobe is a single cycle and follows the settle window.
    a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        fid_stb_o |=> !fid_stb_o);
    a_r6_stb_settled: assert property (@(posedge clk) disable iff (!rst_n)
        fid_stb_o |-> (pg_cnt_q >= K_FID));
    // R3: power-good is taken only after the clock-settle window.
    a_r3_clk_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FID_SETTLE && $past(state_q) == ST_WAIT_PWR) |-> (sup_cnt_q >= K_CLK));
    // R7: fault is sticky and keeps the processor in reset.
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (fault_o && !cpu_rst_n_o && !bridge_rst_n_o));
    // R8: once released, only a fault brings processor reset back.
    a_r8_no_rerun: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_n_o) |-> fault_o);

endmodule

// File: rtl/pwr_seq.sv
// Top of the power-up reset sequencer: synchronizes the asynchronous
// board inputs and hands them to the sequencing state machine.
// Assumes one free-running reference clock and a synchronous active-low reset.
module pwr_seq #(
    parameter int CLK_SETTLE_CYC = 300000,
    parameter int PLL_MIN_CYC    = 100000,
    parameter int RELEASE_CYC    = 175000,
    parameter int FID_SETTLE_CYC = 10,
    parameter int FID_W          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok_i,
    input  logic             pwr_ok_i,
    input  logic             connect_i,
    input  logic [FID_W-1:0] fid_i,
    output logic             bridge_rst_n_o,
    output logic             cpu_rst_n_o,
    output logic             fid_stb_o,
    output logic [FID_W-1:0] fid_o,
    output logic             fault_o
);

    localparam int SYNC_W = FID_W + 3;

    logic [SYNC_W-1:0] raw, synced;

    assign raw = {fid_i, connect_i, pwr_ok_i, supply_ok_i};

    pwr_seq_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    pwr_seq_fsm #(
        .CLK_SETTLE_CYC (CLK_SETTLE_CYC),
        .PLL_MIN_CYC    (PLL_MIN_CYC),
        .RELEASE_CYC    (RELEASE_CYC),
        .FID_SETTLE_CYC (FID_SETTLE_CYC),
        .FID_W          (FID_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sup_s_i        (synced[0]),
        .pg_s_i         (synced[1]),
        .con_s_i        (synced[2]),
        .fid_s_i        (synced[SYNC_W-1:3]),
        .bridge_rst_n_o (bridge_rst_n_o),
        .cpu_rst_n_o    (cpu_rst_n_o),
        .fid_stb_o      (fid_stb_o),
        .fid_o          (fid_o),
        .fault_o        (fault_o)
    );

endmodule

// File: tb/pwr_seq_tb.sv
// Directed bench for the power-up reset sequencer, with short intervals.
module pwr_seq_tb;

    localparam int CLKC = 20;
    localparam int PLLC = 12;
    localparam int RELC = 16;
    localparam int FIDC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0, pwr_ok = 1'b0, connect = 1'b0;
    logic [3:0] fid = 4'h0;
    logic       bridge_rst_n, cpu_rst_n, fid_stb, fault;
    logic [3:0] fid_q;
    int         n_tests = 0, n_fail = 0;

    pwr_seq #(
        .CLK_SETTLE_CYC (CLKC),
        .PLL_MIN_CYC    (PLLC),
        .RELEASE_CYC    (RELC),
        .FID_SETTLE_CYC (FIDC),
        .FID_W          (4)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok_i    (supply_ok),
        .pwr_ok_i       (pwr_ok),
        .connect_i      (connect),
        .fid_i          (fid),
        .bridge_rst_n_o (bridge_rst_n),
        .cpu_rst_n_o    (cpu_rst_n),
        .fid_stb_o      (fid_stb),
        .fid_o          (fid_q),
        .fault_o        (fault)
    );

    always #5 clk = ~clk;

    // Record one comparison; print a FAIL line on mismatch.
    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply controller reset with all inputs low.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; supply_ok = 1'b0; pwr_ok = 1'b0; connect = 1'b0; fid = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count edges after a negedge drive until cpu reset rises (or limit).
    task automatic edges_to_release(input int limit, output int n, output int stb_edge,
                                    output int stb_cnt, output int br_before);
        n = 0; stb_edge = -1; stb_cnt = 0; br_before = -1;
        while (n < limit) begin
            br_before = int'(bridge_rst_n);
            @(posedge clk); n++; #1;
            if (fid_stb) begin
                stb_cnt++;
                if (stb_edge < 0) stb_edge = n;
            end
            if (cpu_rst_n) break;
        end
    endtask

    // Count edges after a negedge drive until fault rises.
    task automatic edges_to_fault(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk); n++; #1;
            if (fault) break;
        end
    endtask

    // Bring supply up, wait the clock settle, connect seen, then sit in wait-power.
    task automatic to_wait_pwr();
        do_reset();
        @(negedge clk); supply_ok = 1'b1; connect = 1'b1;
        repeat (CLKC + 6) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R1 cpu_rst_n", int'(cpu_rst_n), 0);
        chk("R1 bridge_rst_n", int'(bridge_rst_n), 0);
        chk("R1 strobe", int'(fid_stb), 0);
        chk("R1 fault", int'(fault), 0);
        chk("R1 fid_o", int'(fid_q), 0);
    endtask

    task automatic t_normal_boot();
        int n, se, sc, bb;
        to_wait_pwr();
        fid = 4'hA;
        @(negedge clk); pwr_ok = 1'b1;
        edges_to_release(200, n, se, sc, bb);
        chk("R4 R2 release edge", n, RELC + 3);
        chk("R6 strobe edge", se, FIDC + 3);
        chk("R6 strobe count", sc, 1);
        chk("R6 captured code", int'(fid_q), 4'hA);
        chk("R9 bridge low before release", bb, 0);
        chk("R9 bridge released with cpu", int'(bridge_rst_n), 1);
        @(negedge clk); fid = 4'h5; connect = 1'b0; supply_ok = 1'b0;
        repeat (30) @(negedge clk);
        chk("R6 code held after capture", int'(fid_q), 4'hA);
        chk("R8 cpu stays released", int'(cpu_rst_n), 1);
        chk("R8 no extra strobe", int'(fid_stb), 0);
    endtask

    task automatic t_early_pwr();
        int n, se, sc, bb;
        do_reset();
        @(negedge clk); supply_ok = 1'b1; pwr_ok = 1'b1; connect = 1'b1;
        edges_to_release(400, n, se, sc, bb);
        chk("R3 release with early power-good", n, CLKC + RELC + 4);
    endtask

    task automatic t_no_supply();
        do_reset();
        @(negedge clk); pwr_ok = 1'b1; connect = 1'b1;
        repeat (200) @(negedge clk);
        chk("R3 no supply keeps cpu reset", int'(cpu_rst_n), 0);
        chk("R3 no supply captures nothing", int'(fid_q), 0);
    endtask

    task automatic t_late_connect();
        int n, se, sc, bb;
        do_reset();
        @(negedge clk); supply_ok = 1'b1;
        repeat (CLKC + 6) @(negedge clk);
        pwr_ok = 1'b1;
        repeat (RELC + 40) @(negedge clk);
        chk("R5 held without connect", int'(cpu_rst_n), 0);
        connect = 1'b1;
        edges_to_release(100, n, se, sc, bb);
        chk("R5 release after late connect", n, 4);
    endtask

    task automatic t_fault_hold();
        int n;
        to_wait_pwr();
        pwr_ok = 1'b1;
        repeat (FIDC + 8) @(negedge clk);
        pwr_ok = 1'b0;
        edges_to_fault(50, n);
        chk("R7 fault entry edge", n, 3);
        chk("R7 cpu reset in fault", int'(cpu_rst_n), 0);
        chk("R7 bridge reset in fault", int'(bridge_rst_n), 0);
        @(negedge clk); pwr_ok = 1'b1;
        repeat (RELC + 40) @(negedge clk);
        chk("R7 fault sticky", int'(fault), 1);
        chk("R8 no restart after fault", int'(cpu_rst_n), 0);
        do_reset(); #1;
        chk("R7 controller reset clears fault", int'(fault), 0);
    endtask

    task automatic t_fault_after_release();
        int n, se, sc, bb;
        to_wait_pwr();
        pwr_ok = 1'b1;
        edges_to_release(200, n, se, sc, bb);
        @(negedge clk); pwr_ok = 1'b0;
        edges_to_fault(50, n);
        chk("R8 fault after release edge", n, 3);
        chk("R8 cpu reset reasserted", int'(cpu_rst_n), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_normal_boot();
        t_early_pwr();
        t_no_supply();
        t_late_connect();
        t_fault_hold();
        t_fault_after_release();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule